// File: doc/BRIEF.md
# Input Event Interrupt Controller

This block watches a vector of input lines that have already been brought into the local clock domain. For each line it turns a selected condition into a latched pending flag: a high level, a low level, a rising edge or a falling edge. It also drives a single interrupt request, which is raised while any pending flag is set on a line whose mask bit is on. A masked line still records its events, so software can poll it without taking an interrupt.

Software reaches the block through a small decoded register port. The port has a write strobe, a read strobe, a byte address of which bits [7:2] pick the register, 32-bit write data, and read data that is registered. Through this port software picks the trigger kind and polarity of each line. It edits the mask by a plain load, an AND or an OR. It sets pending flags, or clears them by writing zeros at a separate clear address.

Top module: `ievt_ctrl`

## Requirements
- R1: After the active-low reset the pending flags, trigger kind, trigger polarity, mask, edge shadow and read data are all zero, and `irq_o` is 0.
- R2: A line whose kind bit is 0 sets its pending flag in the cycle after its level is active. The level is active high when its polarity bit is 0 and active low when its polarity bit is 1. The flag is set again every cycle for as long as the level stays active.
- R3: A line whose kind bit is 1 sets its pending flag one cycle after an edge. The edge is taken by comparing the line with a copy of the line delayed by one cycle. Polarity 0 selects a rising edge (now 1, before 0) and polarity 1 selects a falling edge. A line that holds steady causes no event.
- R4: A write at index 0x08 loads the mask. A write at index 0x09 ANDs the data into the mask, and a write at index 0x10 ORs the data into it.
- R5: A write at index 0x11 sets every pending flag whose write data bit is 1 and leaves the other flags unchanged.
- R6: A write at index 0x12 clears every pending flag whose write data bit is 0 and keeps the flags whose data bit is 1.
- R7: When a qualifying event and a clear hit the same line in the same cycle, the pending flag ends up set.
- R8: `irq_o` is 1 exactly when some line has both its pending flag and its mask bit set. A masked line still latches its pending flag.
- R9: Reads return their value zero-extended to 32 bits in the cycle after the read strobe. Index 0x06 returns the kind bits, 0x07 the polarity bits, 0x08 the mask and 0x11 the pending flags. Every other index returns zero. Address bits [1:0] are ignored, and the read data holds its value when no read strobe is given.
- R10: A write at index 0x06 loads the per-line kind bits and a write at index 0x07 loads the per-line polarity bits. Only the low NUM_LINES bits of the write data are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address; bits [7:2] select the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| line_in | input | NUM_LINES | Synchronised input lines |
| pend_flags | output | NUM_LINES | Latched pending flag of each line |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
Two functions of the block can land on the same pending flag in the same clock: a new event from a line, and a software clear of that flag. The bench holds a level-triggered line at its active level, or makes an edge on an edge-triggered line, in the same cycle that it writes zeros at the clear index. It also interleaves random clears with random line activity. The flag is judged in the following cycle against a bench model in which the event wins, and the masked interrupt output is checked in the same way.

// File: rtl/ievt_pkg.sv
package ievt_pkg;

   localparam int DATA_W = 32;
   localparam int IDX_W  = 6;

   // Register word indices decoded from address bits [7:2]
   localparam logic [IDX_W-1:0] IDX_KIND     = 6'h06;
   localparam logic [IDX_W-1:0] IDX_POL      = 6'h07;
   localparam logic [IDX_W-1:0] IDX_MASK     = 6'h08;
   localparam logic [IDX_W-1:0] IDX_MASK_AND = 6'h09;
   localparam logic [IDX_W-1:0] IDX_MASK_OR  = 6'h10;
   localparam logic [IDX_W-1:0] IDX_PEND_SET = 6'h11;
   localparam logic [IDX_W-1:0] IDX_PEND_CLR = 6'h12;

   typedef enum logic [1:0] {
      MASK_HOLD = 2'd0,
      MASK_LOAD = 2'd1,
      MASK_AND  = 2'd2,
      MASK_OR   = 2'd3
   } mask_op_e;

   typedef struct packed {
      logic     kind_wr;
      logic     pol_wr;
      mask_op_e mask_op;
      logic     pend_set;
      logic     pend_clr;
   } wr_dec_t;

endpackage

// File: rtl/ievt_decode.sv
module ievt_decode
   import ievt_pkg::*;
(
   input  logic             wr_i,
   input  logic [IDX_W-1:0] idx_i,
   output wr_dec_t          dec_o
);

   always_comb begin
      dec_o          = '0;
      dec_o.mask_op  = MASK_HOLD;
      if (wr_i) begin
         case (idx_i)
            IDX_KIND:     dec_o.kind_wr  = 1'b1;
            IDX_POL:      dec_o.pol_wr   = 1'b1;
            IDX_MASK:     dec_o.mask_op  = MASK_LOAD;
            IDX_MASK_AND: dec_o.mask_op  = MASK_AND;
            IDX_MASK_OR:  dec_o.mask_op  = MASK_OR;
            IDX_PEND_SET: dec_o.pend_set = 1'b1;
            IDX_PEND_CLR: dec_o.pend_clr = 1'b1;
            default: ;
         endcase
      end
   end

   // R10 / R4: at most one register target per write
   always_comb begin
      a_r10_single_target: assert ($countones({dec_o.kind_wr, dec_o.pol_wr,
                                               dec_o.mask_op != MASK_HOLD,
                                               dec_o.pend_set, dec_o.pend_clr}) <= 1);
   end

endmodule

// File: rtl/ievt_detect.sv
module ievt_detect #(
   parameter int NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_i,
   input  logic [NUM_LINES-1:0] kind_i,
   input  logic [NUM_LINES-1:0] pol_i,
   output logic [NUM_LINES-1:0] evt_o
);

   logic [NUM_LINES-1:0] shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow_q <= '0;
      else        shadow_q <= line_i;
   end

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic rise_w;
      logic fall_w;
      assign rise_w = line_i[g] & ~shadow_q[g];
      assign fall_w = ~line_i[g] & shadow_q[g];

      always_comb begin
         case ({kind_i[g], pol_i[g]})
            2'b00:   evt_o[g] = line_i[g];
            2'b01:   evt_o[g] = ~line_i[g];
            2'b10:   evt_o[g] = rise_w;
            default: evt_o[g] = fall_w;
         endcase
      end
   end

   // R3: an edge-kind line never fires when it matches its shadow
   a_r3_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_o & kind_i & ~(line_i ^ shadow_q)) == '0));

endmodule

// File: rtl/ievt_mask.sv
module ievt_mask
   import ievt_pkg::*;
#(
   parameter int NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  mask_op_e             op_i,
   input  logic [NUM_LINES-1:0] data_i,
   output logic [NUM_LINES-1:0] mask_o
);

   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_LINES-1:0] mask_d;

   always_comb begin
      case (op_i)
         MASK_LOAD: mask_d = data_i;
         MASK_AND:  mask_d = mask_q & data_i;
         MASK_OR:   mask_d = mask_q | data_i;
         default:   mask_d = mask_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

   assign mask_o = mask_q;

   a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == MASK_LOAD) |=> (mask_o == $past(data_i)));
   a_r4_mask_and: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == MASK_AND) |=> ((mask_o & ~$past(mask_o)) == '0));
   a_r4_mask_or: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == MASK_OR) |=> ((mask_o & $past(data_i)) == $past(data_i)));
   a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == MASK_HOLD) |=> $stable(mask_o));

endmodule

// File: rtl/ievt_pending.sv
module ievt_pending #(
   parameter int NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_wr_i,
   input  logic                 clr_wr_i,
   input  logic [NUM_LINES-1:0] data_i,
   input  logic [NUM_LINES-1:0] evt_i,
   output logic [NUM_LINES-1:0] pend_o
);

   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] set_bits;
   logic [NUM_LINES-1:0] clr_bits;
   logic [NUM_LINES-1:0] pend_d;

   assign set_bits = set_wr_i ? data_i  : '0;
   assign clr_bits = clr_wr_i ? ~data_i : '0;
   // event term last so it overrides a clear on the same line
   assign pend_d   = set_bits | (pend_q & ~clr_bits) | evt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   assign pend_o = pend_q;

   a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_o & $past(evt_i)) == $past(evt_i)));
   a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr_i |=> ((pend_o & $past(data_i)) == $past(data_i)));
   a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr_i |=> ((pend_o & ~$past(data_i) & ~$past(evt_i)) == '0));
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(evt_i) & ~$past(set_bits)) == '0));

endmodule

// File: rtl/ievt_ctrl.sv
module ievt_ctrl
   import ievt_pkg::*;
#(
   parameter int NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [7:0]           reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [NUM_LINES-1:0] line_in,
   output logic [NUM_LINES-1:0] pend_flags,
   output logic                 irq_o
);

   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("ievt_ctrl: NUM_LINES must lie in 1..32");
   end

   logic [IDX_W-1:0]     idx_w;
   logic [NUM_LINES-1:0] wdata_w;
   wr_dec_t              dec_w;
   logic [NUM_LINES-1:0] kind_q;
   logic [NUM_LINES-1:0] pol_q;
   logic [NUM_LINES-1:0] mask_w;
   logic [NUM_LINES-1:0] evt_w;
   logic [NUM_LINES-1:0] pend_w;
   logic [DATA_W-1:0]    rd_next;
   logic [DATA_W-1:0]    rdata_q;
   logic                 unused_bits;

   assign idx_w   = reg_addr[7:2];
   assign wdata_w = reg_wdata[NUM_LINES-1:0];
   assign unused_bits = ^{reg_addr[1:0], reg_wdata};

   ievt_decode u_dec (
      .wr_i  (reg_wr),
      .idx_i (idx_w),
      .dec_o (dec_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= '0;
         pol_q  <= '0;
      end else begin
         if (dec_w.kind_wr) kind_q <= wdata_w;
         if (dec_w.pol_wr)  pol_q  <= wdata_w;
      end
   end

   ievt_detect #(.NUM_LINES(NUM_LINES)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_in),
      .kind_i (kind_q),
      .pol_i  (pol_q),
      .evt_o  (evt_w)
   );

   ievt_mask #(.NUM_LINES(NUM_LINES)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_i   (dec_w.mask_op),
      .data_i (wdata_w),
      .mask_o (mask_w)
   );

   ievt_pending #(.NUM_LINES(NUM_LINES)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_wr_i (dec_w.pend_set),
      .clr_wr_i (dec_w.pend_clr),
      .data_i   (wdata_w),
      .evt_i    (evt_w),
      .pend_o   (pend_w)
   );

   always_comb begin
      rd_next = '0;
      case (idx_w)
         IDX_KIND:     rd_next[NUM_LINES-1:0] = kind_q;
         IDX_POL:      rd_next[NUM_LINES-1:0] = pol_q;
         IDX_MASK:     rd_next[NUM_LINES-1:0] = mask_w;
         IDX_PEND_SET: rd_next[NUM_LINES-1:0] = pend_w;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_next;
   end

   assign reg_rdata  = rdata_q;
   assign pend_flags = pend_w;
   assign irq_o      = |(pend_w & mask_w);

   a_r9_read_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && idx_w == IDX_PEND_SET) |=> (reg_rdata[NUM_LINES-1:0] == $past(pend_flags)));
   a_r9_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));
   a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pend_flags != '0));

endmodule

// File: tb/ievt_ctrl_test.sv
module ievt_ctrl_test;
   import ievt_pkg::*;

   localparam int  NL     = 12;
   localparam time PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          reg_wr, reg_rd;
   logic [7:0]    reg_addr;
   logic [31:0]   reg_wdata;
   logic [31:0]   reg_rdata;
   logic [NL-1:0] line_in;
   logic [NL-1:0] pend_flags;
   logic          irq_o;

   always #(PERIOD/2) clk = ~clk;

   ievt_ctrl #(.NUM_LINES(NL)) uut (
      .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
      .line_in, .pend_flags, .irq_o
   );

   // bench model state
   logic [NL-1:0] m_kind, m_pol, m_mask, m_pend, m_shadow, cur_line;
   logic [31:0]   m_rdata;
   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [NL-1:0] f_evt(logic [NL-1:0] ln, logic [NL-1:0] sh,
                                           logic [NL-1:0] k, logic [NL-1:0] p);
      logic [NL-1:0] e;
      for (int i = 0; i < NL; i++) begin
         if (!k[i]) e[i] = p[i] ? ~ln[i] : ln[i];
         else       e[i] = p[i] ? (~ln[i] & sh[i]) : (ln[i] & ~sh[i]);
      end
      return e;
   endfunction

   function automatic logic [31:0] f_read(logic [5:0] idx);
      logic [31:0] r = '0;
      if      (idx == 6'h06) r[NL-1:0] = m_kind;
      else if (idx == 6'h07) r[NL-1:0] = m_pol;
      else if (idx == 6'h08) r[NL-1:0] = m_mask;
      else if (idx == 6'h11) r[NL-1:0] = m_pend;
      return r;
   endfunction

   task automatic cyc(string tag, bit wr, bit rd, logic [7:0] a, logic [31:0] d);
      logic [NL-1:0] evt, dn, np;
      logic [5:0]    idx;
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; line_in = cur_line;
      @(posedge clk);
      idx = a[7:2];
      dn  = d[NL-1:0];
      evt = f_evt(cur_line, m_shadow, m_kind, m_pol);
      if (rd) m_rdata = f_read(idx);
      np = m_pend | evt;
      if (wr) begin
         if (idx == 6'h11) np = np | dn;
         if (idx == 6'h12) np = (m_pend & dn) | evt;
         if (idx == 6'h06) m_kind = dn;
         if (idx == 6'h07) m_pol  = dn;
         if (idx == 6'h08) m_mask = dn;
         if (idx == 6'h09) m_mask = m_mask & dn;
         if (idx == 6'h10) m_mask = m_mask | dn;
      end
      m_pend   = np;
      m_shadow = cur_line;
      #1;
      chk(tag, "pending", 32'(pend_flags), 32'(m_pend));
      chk(tag, "irq", 32'(irq_o), 32'(|(m_pend & m_mask)));
      chk(tag, "rdata", reg_rdata, m_rdata);
   endtask

   task automatic wr(string tag, logic [5:0] idx, logic [31:0] d);
      cyc(tag, 1'b1, 1'b0, {idx, 2'b00}, d);
   endtask

   task automatic rd(string tag, logic [5:0] idx);
      cyc(tag, 1'b0, 1'b1, {idx, 2'b00}, 32'h0);
   endtask

   task automatic idle(string tag);
      cyc(tag, 1'b0, 1'b0, 8'h00, 32'hFFFF_FFFF);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [5:0] pick [9];
      pick = '{6'h06, 6'h07, 6'h08, 6'h09, 6'h10, 6'h11, 6'h12, 6'h05, 6'h3F};
      m_kind = '0; m_pol = '0; m_mask = '0; m_pend = '0; m_shadow = '0;
      m_rdata = '0; cur_line = '0;
      rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
      reg_wdata = '0; line_in = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs in reset
      chk("R1", "pending in reset", 32'(pend_flags), 32'h0);
      chk("R1", "irq in reset", 32'(irq_o), 32'h0);
      chk("R1", "rdata in reset", reg_rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: every register reads zero after reset
      rd("R1", 6'h06); rd("R1", 6'h07); rd("R1", 6'h08); rd("R1", 6'h11);

      // R10: kind and polarity loads, upper data bits dropped
      wr("R10", 6'h06, 32'hFFFF_FA5A);
      wr("R10", 6'h07, 32'h0000_03C3);
      rd("R10", 6'h06); rd("R10", 6'h07);
      // quiet setup: all edge, rising, lines low
      wr("R10", 6'h06, 32'hFFF); wr("R10", 6'h07, 32'h000);
      wr("R6", 6'h12, 32'h000);
      rd("R6", 6'h11);

      // R4: mask load / AND / OR
      wr("R4", 6'h08, 32'hF0F); rd("R4", 6'h08);
      wr("R4", 6'h09, 32'h0FF); rd("R4", 6'h08);
      wr("R4", 6'h10, 32'h00A); rd("R4", 6'h08);

      // R5: set pending bits
      wr("R5", 6'h11, 32'h123); rd("R5", 6'h11);
      // R6: clear where data is zero
      wr("R6", 6'h12, 32'hF0E); rd("R6", 6'h11);

      // R8: masked pending gives no irq, unmasked does
      wr("R8", 6'h08, 32'h000); idle("R8");
      wr("R8", 6'h11, 32'h800); idle("R8");
      wr("R8", 6'h08, 32'h800); idle("R8");
      wr("R6", 6'h12, 32'h000); idle("R8");

      // R2: level high on line 0, level low on line 1
      wr("R2", 6'h06, 32'hFFC); wr("R2", 6'h07, 32'h002);
      cur_line = 12'h003;  // line 1 is high, so not active low
      idle("R2"); idle("R2");
      cur_line = 12'h001;  // line 1 now low
      idle("R2");
      // R7: clear while level still active
      wr("R7", 6'h12, 32'h000); idle("R7");
      cur_line = 12'h002;
      idle("R2");
      wr("R2", 6'h12, 32'h000); rd("R2", 6'h11);

      // R3: rising on line 2, falling on line 3
      wr("R3", 6'h06, 32'hFFF); wr("R3", 6'h07, 32'h008);
      cur_line = 12'h008;
      idle("R3");
      wr("R3", 6'h12, 32'h000);
      idle("R3"); idle("R3");          // steady: nothing sets
      cur_line = 12'h004;               // rise on 2, fall on 3
      idle("R3");
      wr("R3", 6'h12, 32'h000); idle("R3");
      cur_line = 12'h000;               // fall on 2: polarity 0 ignores it
      idle("R3");
      cur_line = 12'h004;               // R7: rise coincides with clear
      wr("R7", 6'h12, 32'h000); idle("R7");

      // R9: unused indices read zero, low address bits ignored, hold
      rd("R9", 6'h09); rd("R9", 6'h10); rd("R9", 6'h12); rd("R9", 6'h05);
      cyc("R9", 1'b0, 1'b1, {6'h11, 2'b11}, 32'h0);
      idle("R9"); idle("R9");

      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[3:0] < 4) cur_line = cur_line ^ NL'($urandom);
         cyc("R2/R3/R4/R5/R6/R7/R8/R9 random", r[4], r[5],
             {pick[r[9:6] % 9], r[11:10]}, $urandom);
      end
      summary();
   end

endmodule